// File: doc/BRIEF.md
# Pseudo-SRAM Power-Up and Software-Reset Sequencer

This block follows the device side of a serial pseudo-SRAM from the moment its supply is declared stable until it may serve normal traffic. Two conditions must both be met. First, a settle interval must pass, measured as a parameterised number of ticks from an on-chip microsecond timebase. Second, a software reset must complete. The two may finish in either order. The ready flag goes high only once both have happened. If the supply-stable bit drops, the whole sequence starts again.

A software reset takes two commands. A reset-enable command arms a latch, and a reset command fires it. The reset takes effect only when it is the very next decoded command after the reset-enable. Any other command in between disarms the latch. A fired reset pulses two outputs for one cycle. One pulse sends the interface logic back to single-line SPI standby. The other sends the burst logic back to linear bursts. The command strobes come already decoded from the command front end and are accepted in any interface mode.

While the settle window is open, the pad levels (chip select, clock, data) must stay quiet. A monitor raises a one-cycle flag for any activity it sees in that window.

Top module: `psram_boot_ctrl`

## Requirements
- R1: With `vdd_ok_i` held high, the settle interval completes on the clock edge that samples the SETTLE_TICKS-th `tick_i` pulse. `ready_o` stays low while fewer ticks than that have been counted.
- R2: `ready_o` is high exactly when the settle interval is complete and a reset has fired since the supply became stable. The two may finish in either order. If the reset fires last, `ready_o` rises one cycle after the reset pulse. If the settle interval finishes last, `ready_o` rises right after the edge that samples the last tick.
- R3: A reset command (code 8'h99) that is the next strobed command after a reset-enable (code 8'h66) raises `spi_dflt_o` and `lin_burst_o` for exactly one cycle. The pulse follows the clock edge that samples the reset command.
- R4: A reset-enable followed by any other command code disarms the latch, so a later reset command produces no pulse. A reset command with no pending reset-enable produces no pulse.
- R5: Cycles in which `cmd_vld_i` is low do not disarm the latch. A second reset-enable leaves the latch armed.
- R6: While `vdd_ok_i` is low, the settle count, the reset record and the arm latch are all cleared, and commands are ignored. `ready_o` is low from the edge after `vdd_ok_i` falls.
- R7: During the settle window (`vdd_ok_i` high, interval not complete), any of these conditions raises `pin_fault_o` for one cycle after the edge that samples it: `cs_n_i` low, `sclk_i` high, or `dq_i` nonzero. Outside the window, pad activity raises no flag.
- R8: A reset that fires while `ready_o` is high still pulses both default outputs, and `ready_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vdd_ok_i | input | 1 | Supply-stable indication |
| tick_i | input | 1 | One-cycle microsecond timebase pulse |
| cmd_vld_i | input | 1 | Decoded command strobe |
| cmd_code_i | input | CMD_W | Code of the strobed command |
| cs_n_i | input | 1 | Chip-select pad level |
| sclk_i | input | 1 | Serial clock pad level |
| dq_i | input | DQ_W | Data pad levels |
| ready_o | output | 1 | Device ready for normal operation |
| spi_dflt_o | output | 1 | One-cycle pulse: return interface to SPI standby |
| lin_burst_o | output | 1 | One-cycle pulse: return burst mode to linear |
| pin_fault_o | output | 1 | One-cycle pulse: pad activity during the settle window |

## Verification
Each result appears a fixed number of edges after its stimulus. The reset pulses and the pin-fault flag show up one edge after the sampled strobe or pad level. A reset-driven rise of `ready_o` comes one edge after that. A tick-driven rise comes on the sampling edge itself, and so does the drop after a supply loss. The bench drives every input at the falling edge and lets exactly one rising edge pass before it compares. It then checks the following falling edge as well, which confirms each pulse lasts a single cycle. Cancel and no-effect cases are judged at the same point, where a pulse would otherwise have appeared.

// File: rtl/psram_boot_pkg.sv
package psram_boot_pkg;
   localparam logic [7:0] CODE_RST_ARM  = 8'h66;
   localparam logic [7:0] CODE_RST_FIRE = 8'h99;

   typedef enum logic [0:0] {
      ARM_IDLE = 1'b0,
      ARM_SET  = 1'b1
   } arm_state_e;
endpackage

// File: rtl/boot_settle_timer.sv
module boot_settle_timer #(
   parameter int unsigned TICKS = 150
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic vdd_ok_i,
   input  logic tick_i,
   output logic done_o
);
   localparam int unsigned CNT_W = $clog2(TICKS + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TICKS);

   if (TICKS < 1) begin : g_bad_ticks
      $error("boot_settle_timer: TICKS must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (!vdd_ok_i) begin
         cnt_q <= '0;
      end else if (tick_i && (cnt_q != LIMIT)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done_o = (cnt_q == LIMIT);

   // R1: count never passes its limit
   a_r1_cnt_bound : assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LIMIT);
   // R6: completion is lost only through a supply drop
   a_r6_done_drop : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(done_o) |-> !$past(vdd_ok_i));
endmodule

// File: rtl/boot_rst_arbiter.sv
module boot_rst_arbiter
   import psram_boot_pkg::*;
#(
   parameter int unsigned CMD_W = 8,
   parameter logic [CMD_W-1:0] ARM_CODE  = CMD_W'(CODE_RST_ARM),
   parameter logic [CMD_W-1:0] FIRE_CODE = CMD_W'(CODE_RST_FIRE)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             enable_i,
   input  logic             cmd_vld_i,
   input  logic [CMD_W-1:0] cmd_code_i,
   output logic             fire_o
);
   if (CMD_W < 8) begin : g_bad_width
      $error("boot_rst_arbiter: CMD_W must be at least 8");
   end
   if (ARM_CODE == FIRE_CODE) begin : g_bad_codes
      $error("boot_rst_arbiter: arm and fire codes must differ");
   end

   arm_state_e state_q, state_d;
   logic       fire_q, fire_d;
   logic       is_arm, is_fire;

   assign is_arm  = (cmd_code_i == ARM_CODE);
   assign is_fire = (cmd_code_i == FIRE_CODE);

   always_comb begin
      state_d = state_q;
      fire_d  = 1'b0;
      if (!enable_i) begin
         state_d = ARM_IDLE;
      end else if (cmd_vld_i) begin
         if (is_arm) begin
            state_d = ARM_SET;
         end else begin
            fire_d  = is_fire && (state_q == ARM_SET);
            state_d = ARM_IDLE;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ARM_IDLE;
         fire_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         fire_q  <= fire_d;
      end
   end

   assign fire_o = fire_q;

   // R3: a fire needs an armed latch one cycle earlier
   a_r3_fire_armed : assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_q |-> $past(state_q == ARM_SET));
   // R4: a non-arm command always leaves the latch idle
   a_r4_cancel : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(cmd_vld_i && !is_arm) |-> (state_q == ARM_IDLE));
   // R5: idle cycles keep the latch as it was
   a_r5_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(enable_i && !cmd_vld_i) |-> $stable(state_q));
   // R3: fire lasts a single cycle
   a_r3_single : assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_q |=> !fire_q);
endmodule

// File: rtl/boot_pin_monitor.sv
module boot_pin_monitor #(
   parameter int unsigned DQ_W = 4
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            window_i,
   input  logic            cs_n_i,
   input  logic            sclk_i,
   input  logic [DQ_W-1:0] dq_i,
   output logic            fault_o
);
   if (DQ_W < 1) begin : g_bad_dq
      $error("boot_pin_monitor: DQ_W must be at least 1");
   end

   logic [DQ_W+1:0] act;

   assign act[0] = !cs_n_i;
   assign act[1] = sclk_i;
   for (genvar gi = 0; gi < DQ_W; gi++) begin : g_dq
      assign act[gi+2] = dq_i[gi];
   end

   logic fault_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fault_q <= 1'b0;
      else         fault_q <= window_i && (|act);
   end

   assign fault_o = fault_q;

   // R7: a flag only follows a window cycle
   a_r7_in_window : assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_q |-> $past(window_i));
endmodule

// File: rtl/psram_boot_ctrl.sv
module psram_boot_ctrl #(
   parameter int unsigned SETTLE_TICKS = 150,
   parameter int unsigned CMD_W        = 8,
   parameter int unsigned DQ_W         = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             vdd_ok_i,
   input  logic             tick_i,
   input  logic             cmd_vld_i,
   input  logic [CMD_W-1:0] cmd_code_i,
   input  logic             cs_n_i,
   input  logic             sclk_i,
   input  logic [DQ_W-1:0]  dq_i,
   output logic             ready_o,
   output logic             spi_dflt_o,
   output logic             lin_burst_o,
   output logic             pin_fault_o
);
   logic settle_done;
   logic fire;
   logic rst_seen_q;

   boot_settle_timer #(.TICKS(SETTLE_TICKS)) u_timer (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .vdd_ok_i (vdd_ok_i),
      .tick_i   (tick_i),
      .done_o   (settle_done)
   );

   boot_rst_arbiter #(.CMD_W(CMD_W)) u_arb (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .enable_i   (vdd_ok_i),
      .cmd_vld_i  (cmd_vld_i),
      .cmd_code_i (cmd_code_i),
      .fire_o     (fire)
   );

   boot_pin_monitor #(.DQ_W(DQ_W)) u_mon (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .window_i (vdd_ok_i && !settle_done),
      .cs_n_i   (cs_n_i),
      .sclk_i   (sclk_i),
      .dq_i     (dq_i),
      .fault_o  (pin_fault_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        rst_seen_q <= 1'b0;
      else if (!vdd_ok_i) rst_seen_q <= 1'b0;
      else if (fire)      rst_seen_q <= 1'b1;
   end

   assign ready_o     = settle_done && rst_seen_q;
   assign spi_dflt_o  = fire;
   assign lin_burst_o = fire;

   // R6: supply loss drops ready on the next edge
   a_r6_vdd_loss : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !vdd_ok_i |=> !ready_o);
   // R2: ready rises only with the supply up in the cycle before
   a_r2_rise_supply : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ready_o) |-> $past(vdd_ok_i));
   // R8: a fire never lowers ready
   a_r8_keep_ready : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ready_o && fire && vdd_ok_i) |=> ready_o);
endmodule

// File: tb/psram_boot_ctrl_tb.sv
module psram_boot_ctrl_tb_top;
   localparam int unsigned N = 150;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       vdd = 1'b0, tick = 1'b0, vld = 1'b0;
   logic [7:0] code = 8'h00;
   logic       cs_n = 1'b1, sclk = 1'b0;
   logic [3:0] dq = 4'h0;
   logic       ready, spi_d, lin_d, fault;
   int         n_chk = 0, n_bad = 0;
   bit         finished = 1'b0;

   always #4 clk = ~clk;

   psram_boot_ctrl #(.SETTLE_TICKS(N)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .vdd_ok_i(vdd), .tick_i(tick),
      .cmd_vld_i(vld), .cmd_code_i(code), .cs_n_i(cs_n), .sclk_i(sclk),
      .dq_i(dq), .ready_o(ready), .spi_dflt_o(spi_d), .lin_burst_o(lin_d),
      .pin_fault_o(fault)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] c);
      @(negedge clk); vld = 1'b1; code = c;
      @(negedge clk); vld = 1'b0; code = 8'h00;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic pulse_chk(input string req, input logic exp);
      chk(req, spi_d, exp);
      chk(req, lin_d, exp);
      @(negedge clk);
      chk({req, " one cycle"}, spi_d, 1'b0);
   endtask

   task automatic t_reset_state;
      chk("reset ready", ready, 1'b0);
      chk("reset R3 pulse", spi_d, 1'b0);
      chk("reset R7 fault", fault, 1'b0);
   endtask

   task automatic t_partial_count;
      @(negedge clk); vdd = 1'b1;
      ticks(N - 10);
      chk("R1 partial count", ready, 1'b0);
   endtask

   task automatic t_pin_fault;
      @(negedge clk); sclk = 1'b1;
      @(negedge clk); sclk = 1'b0;
      chk("R7 sclk fault", fault, 1'b1);
      @(negedge clk);
      chk("R7 fault one cycle", fault, 1'b0);
      @(negedge clk); dq = 4'h4;
      @(negedge clk); dq = 4'h0;
      chk("R7 dq fault", fault, 1'b1);
   endtask

   task automatic t_cancel;
      send(8'h66); send(8'h03); send(8'h99);
      pulse_chk("R4 cancelled", 1'b0);
      send(8'h99);
      pulse_chk("R4 fire without arm", 1'b0);
   endtask

   task automatic t_gap_fire;
      @(negedge clk); vld = 1'b1; code = 8'h66;
      @(negedge clk); vld = 1'b0;
      repeat (3) @(negedge clk);
      vld = 1'b1; code = 8'h99;
      @(negedge clk); vld = 1'b0;
      chk("R5 idle gap fire", spi_d, 1'b1);
      chk("R3 burst default", lin_d, 1'b1);
      @(negedge clk);
      chk("R3 pulse one cycle", spi_d, 1'b0);
      chk("R2 reset before settle", ready, 1'b0);
   endtask

   task automatic t_finish_count;
      ticks(9);
      chk("R1 one tick short", ready, 1'b0);
      ticks(1);
      chk("R1 R2 settle last", ready, 1'b1);
   endtask

   task automatic t_double_arm;
      send(8'h66); send(8'h66); send(8'h99);
      chk("R5 double arm", spi_d, 1'b1);
      chk("R8 ready kept", ready, 1'b1);
      @(negedge clk);
      chk("R8 ready after", ready, 1'b1);
   endtask

   task automatic t_supply_loss;
      @(negedge clk); vdd = 1'b0;
      @(negedge clk);
      chk("R6 ready drop", ready, 1'b0);
      send(8'h66);
      @(negedge clk); vdd = 1'b1;
      send(8'h99);
      pulse_chk("R6 arm ignored", 1'b0);
      ticks(N);
      chk("R2 count without reset", ready, 1'b0);
      @(negedge clk); cs_n = 1'b0;
      @(negedge clk); cs_n = 1'b1;
      chk("R7 no fault after window", fault, 1'b0);
      send(8'h66); send(8'h99);
      chk("R3 fire after count", spi_d, 1'b1);
      chk("R2 ready lags fire", ready, 1'b0);
      @(negedge clk);
      chk("R2 reset last", ready, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_partial_count();
      t_pin_fault();
      t_cancel();
      t_gap_fire();
      t_finish_count();
      t_double_arm();
      t_supply_loss();
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule